// File: doc/BRIEF.md
# DDR Write Burst Sequencer

This block sits between the phase-converted controller interface and the DRAM data pins. Each accepted write command launches a sequence on the pins. The strobe is driven low for a preamble. The burst data and its byte masks are then clocked out, one beat per clock, with the strobe toggling on every beat. An optional two-beat CRC follows. A postamble closes the sequence. If a second write arrives while a burst is still on the pins, the block chains it with an inter-amble in place of the postamble and a fresh preamble.

The command path supplies three settings: the preamble and postamble lengths in clock cycles and the CRC enable. These are captured when an idle block accepts a write. The burst length, 8 or 16 beats, arrives with each command. Data is pulled through a take strobe. The beat driven on `wr_data` in a cycle where `data_take` is high appears on `dq` one clock later. The CRC uses the polynomial x^8+x^2+x+1 and runs independently on every 4-bit DQ lane.

Top module: `ddr_wr_sequencer`

## Requirements
- R1: While reset is held, every output is 0: `dq`, `dm`, `dq_oe`, `dqs`, `dqs_oe` and `data_take`.
- R2: A `wr_req` seen in idle starts a preamble of `cfg_pre_cyc`+1 clock cycles, during which `dqs_oe` is 1, `dqs` is 0 and `dq_oe` is 0 on the outputs.
- R3: `data_take` is high for 16 consecutive cycles when the accepted command had `wr_bl16`=1, and for 8 otherwise. Each beat present on `wr_data`/`wr_mask` in a take cycle is driven on `dq`/`dm` with `dq_oe`=1 in the following cycle. Data offered outside take cycles never reaches the pins.
- R4: During data and CRC beats `dqs` toggles every cycle, starting at 1 on the first beat. It is 0 in every non-beat cycle.
- R5: When CRC is enabled and the burst has 16 beats, two CRC beats follow the data, with `dm`=0. DQ lane g (bits 4g..4g+3) carries the lane's code bits [3:0] in the first beat and bits [7:4] in the second. The code is the remainder of the lane's 64-bit stream times x^8, divided by x^8+x^2+x+1, with an initial value of 0. The stream runs in beat order and, within a beat, from bit 4g upwards, and its first bit is the highest power.
- R6: With CRC disabled, or for an 8-beat burst, no CRC beats are sent. The postamble or inter-amble follows the last data beat directly.
- R7: After the last beat with no write pending, a postamble of `cfg_post_cyc`+1 cycles follows with `dqs_oe`=1 and `dqs`=0. One cycle with all outputs off comes next, after which the block is idle.
- R8: A `wr_req` in any data or CRC cycle is queued together with its `wr_bl16`. When the current burst ends, an inter-amble of `cfg_pre_cyc`+1 cycles follows (`dqs_oe`=1, `dqs`=0). The queued burst then runs without a postamble in between.
- R9: A `wr_req` during preamble, inter-amble, postamble or the closing off cycle has no effect. So does a second `wr_req` while one is already queued.
- R10: `cfg_pre_cyc`, `cfg_post_cyc` and `cfg_crc_en` are sampled only when an idle block accepts a write. Changing them later does not alter the running sequence or a chained burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one beat per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pre_cyc | input | AMB_W | Preamble and inter-amble length minus one, in cycles |
| cfg_post_cyc | input | AMB_W | Postamble length minus one, in cycles |
| cfg_crc_en | input | 1 | Append CRC to 16-beat bursts |
| wr_req | input | 1 | Write command strobe |
| wr_bl16 | input | 1 | Burst length of this command: 1 = 16 beats, 0 = 8 |
| data_take | output | 1 | Current `wr_data`/`wr_mask` beat is consumed at the next edge |
| wr_data | input | DQ_W | Write data beat |
| wr_mask | input | DQ_W/8 | Write mask beat, one bit per byte |
| dq | output | DQ_W | Data pins |
| dm | output | DQ_W/8 | Mask pins |
| dq_oe | output | 1 | Data pin drive enable |
| dqs | output | 1 | Strobe level |
| dqs_oe | output | 1 | Strobe drive enable |

## Verification
The bound checker watches the strobe framing on every cycle. The strobe stays low whenever it is driven outside a beat, and toggles on every beat starting high. A burst never starts without a preceding preamble or inter-amble, and the strobe stays driven in the cycle after the data drive drops. A take cycle always yields a driven data beat one cycle later. Only the bench's sweeps can show the cycle counts of each amble, the burst lengths, the CRC values per lane, the queuing of a second write at different points of a burst, and that stray requests and late settings changes have no effect.

// File: rtl/ddr_wr_sequencer.sv
module ddr_wr_sequencer #(
  parameter int DQ_W  = 8,
  parameter int AMB_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AMB_W-1:0]    cfg_pre_cyc,
  input  logic [AMB_W-1:0]    cfg_post_cyc,
  input  logic                cfg_crc_en,
  input  logic                wr_req,
  input  logic                wr_bl16,
  output logic                data_take,
  input  logic [DQ_W-1:0]     wr_data,
  input  logic [DQ_W/8-1:0]   wr_mask,
  output logic [DQ_W-1:0]     dq,
  output logic [DQ_W/8-1:0]   dm,
  output logic                dq_oe,
  output logic                dqs,
  output logic                dqs_oe
);
  localparam int DM_W  = DQ_W / 8;
  localparam int LANES = DQ_W / 4;
  localparam int CW    = (AMB_W > 5) ? AMB_W : 5;

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_DATA, S_CRC, S_INTER, S_POST, S_DONE
  } st_t;

  st_t                 st;
  logic [CW-1:0]       cnt;
  logic                bl_q, pend_q, pend_bl_q, crc_q;
  logic [AMB_W-1:0]    pre_q, post_q;
  logic [LANES*8-1:0]  crc_r;
  logic [DQ_W-1:0]     dq_q;
  logic [DM_W-1:0]     dm_q;
  logic                dq_oe_q, dqs_q, dqs_oe_q;

  function automatic logic [7:0] crc_nib(input logic [7:0] c, input logic [3:0] d);
    logic [7:0] r;
    logic       fb;
    r = c;
    for (int i = 0; i < 4; i++) begin
      fb = r[7] ^ d[i];
      r  = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return r;
  endfunction

  wire in_burst = (st == S_DATA) || (st == S_CRC);
  wire req_q    = wr_req && in_burst && !pend_q;
  wire pend_any = pend_q || req_q;
  wire nxt_bl   = pend_q ? pend_bl_q : wr_bl16;
  wire last     = (cnt == '0);
  wire to_crc   = crc_q && bl_q;

  wire [CW-1:0] pre_ld  = CW'(pre_q);
  wire [CW-1:0] post_ld = CW'(post_q);
  wire [CW-1:0] bl_ld   = bl_q ? CW'(15) : CW'(7);

  assign data_take = (st == S_DATA);
  assign dq        = dq_q;
  assign dm        = dm_q;
  assign dq_oe     = dq_oe_q;
  assign dqs       = dqs_q;
  assign dqs_oe    = dqs_oe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      bl_q      <= 1'b0;
      pend_q    <= 1'b0;
      pend_bl_q <= 1'b0;
      crc_q     <= 1'b0;
      pre_q     <= '0;
      post_q    <= '0;
      crc_r     <= '0;
      dq_q      <= '0;
      dm_q      <= '0;
      dq_oe_q   <= 1'b0;
      dqs_q     <= 1'b0;
      dqs_oe_q  <= 1'b0;
    end else begin
      dq_oe_q  <= in_burst;
      dqs_oe_q <= (st != S_IDLE) && (st != S_DONE);
      dqs_q    <= in_burst ? ~dqs_q : 1'b0;

      if (st == S_DATA) begin
        dq_q <= wr_data;
        dm_q <= wr_mask;
        for (int g = 0; g < LANES; g++)
          crc_r[8*g +: 8] <= crc_nib(crc_r[8*g +: 8], wr_data[4*g +: 4]);
      end else if (st == S_CRC) begin
        dm_q <= '0;
        for (int g = 0; g < LANES; g++)
          dq_q[4*g +: 4] <= cnt[0] ? crc_r[8*g +: 4] : crc_r[8*g+4 +: 4];
      end else begin
        dq_q <= '0;
        dm_q <= '0;
      end

      if (req_q) begin
        pend_q    <= 1'b1;
        pend_bl_q <= wr_bl16;
      end

      case (st)
        S_IDLE: if (wr_req) begin
          st     <= S_PRE;
          cnt    <= CW'(cfg_pre_cyc);
          pre_q  <= cfg_pre_cyc;
          post_q <= cfg_post_cyc;
          crc_q  <= cfg_crc_en;
          bl_q   <= wr_bl16;
        end
        S_PRE, S_INTER: begin
          if (last) begin
            st    <= S_DATA;
            cnt   <= bl_ld;
            crc_r <= '0;
          end else cnt <= cnt - 1'b1;
        end
        S_DATA, S_CRC: begin
          if (!last) cnt <= cnt - 1'b1;
          else if (st == S_DATA && to_crc) begin
            st  <= S_CRC;
            cnt <= CW'(1);
          end else if (pend_any) begin
            st     <= S_INTER;
            cnt    <= pre_ld;
            bl_q   <= nxt_bl;
            pend_q <= 1'b0;
          end else begin
            st  <= S_POST;
            cnt <= post_ld;
          end
        end
        S_POST: begin
          if (last) st <= S_DONE;
          else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module ddr_wr_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic data_take,
  input logic dq_oe,
  input logic dqs,
  input logic dqs_oe
);
  p_strobe_low_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dqs_oe && !dq_oe) |-> !dqs);

  p_data_needs_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> dqs_oe);

  p_take_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
    data_take |=> dq_oe);

  p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> (dqs != $past(dqs)));

  p_first_beat_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> dqs);

  p_preamble_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_take) |-> (dqs_oe && !dq_oe));

  p_tail_amble_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> dqs_oe);
endmodule

bind ddr_wr_sequencer ddr_wr_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .data_take(data_take),
  .dq_oe(dq_oe), .dqs(dqs), .dqs_oe(dqs_oe)
);

// File: tb/ddr_wr_sequencer_test.sv
module ddr_wr_sequencer_test;
  localparam int CLK_NS = 10;
  localparam int DQ_W = 8;
  localparam int AMB_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AMB_W-1:0] cfg_pre_cyc = '0, cfg_post_cyc = '0;
  logic cfg_crc_en = 1'b0, wr_req = 1'b0, wr_bl16 = 1'b0;
  logic [DQ_W-1:0] wr_data = '0;
  logic [0:0] wr_mask = '0;
  logic data_take, dq_oe, dqs, dqs_oe;
  logic [DQ_W-1:0] dq;
  logic [0:0] dm;

  int vectors = 0, fails = 0;

  ddr_wr_sequencer #(.DQ_W(DQ_W), .AMB_W(AMB_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_pre_cyc(cfg_pre_cyc), .cfg_post_cyc(cfg_post_cyc),
    .cfg_crc_en(cfg_crc_en), .wr_req(wr_req), .wr_bl16(wr_bl16), .data_take(data_take),
    .wr_data(wr_data), .wr_mask(wr_mask), .dq(dq), .dm(dm), .dq_oe(dq_oe),
    .dqs(dqs), .dqs_oe(dqs_oe)
  );

  always #(CLK_NS/2) clk = ~clk;

  logic [7:0] dA[16], dB[16];
  logic       mA[16], mB[16];
  int         ph[128];
  logic [7:0] edq[128], drv[128];
  logic       edm[128], drvm[128], eds[128];
  bit         sk6[128];
  int         n, idx_post, idx_done;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_ref(input bit second, input int lane);
    logic [8:0] r = '0;
    logic       b;
    for (int k = 0; k < 72; k++) begin
      b = 1'b0;
      if (k < 64) b = second ? dB[k/4][4*lane + k%4] : dA[k/4][4*lane + k%4];
      r = {r[7:0], b};
      if (r[8]) r = r ^ 9'h107;
    end
    return r[7:0];
  endfunction

  task automatic push(input int p, input logic [7:0] q, input logic m, input logic s);
    ph[n] = p; edq[n] = q; edm[n] = m; eds[n] = s;
    drv[n] = 8'($urandom); drvm[n] = 1'($urandom); sk6[n] = 0;
    n++;
  endtask

  task automatic add_burst(input bit second, input int pre, input bit crc, input bit b16, input int ptype);
    int len = b16 ? 16 : 8;
    logic [7:0] c0, c1;
    for (int i = 0; i <= pre; i++) push(ptype, 8'h00, 1'b0, 1'b0);
    for (int j = 0; j < len; j++) begin
      push(2, second ? dB[j] : dA[j], second ? mB[j] : mA[j], (j % 2) == 0);
      drv[n-1] = edq[n-1]; drvm[n-1] = edm[n-1];
    end
    if (crc && b16) begin
      c0 = crc_ref(second, 0); c1 = crc_ref(second, 1);
      push(3, {c1[3:0], c0[3:0]}, 1'b0, 1'b1);
      push(3, {c1[7:4], c0[7:4]}, 1'b0, 1'b0);
    end
  endtask

  task automatic run(input int pre, input int post, input bit crc, input bit bla,
                     input bit two, input bit blb, input int pos);
    int req2 = -1, s1, s2, cA, p;
    bit skipA;
    string tag;
    for (int j = 0; j < 16; j++) begin
      dA[j] = 8'($urandom); dB[j] = 8'($urandom);
      mA[j] = 1'($urandom); mB[j] = 1'($urandom);
    end
    n = 0;
    cA = (crc && bla) ? 2 : 0;
    skipA = !(crc && bla);
    add_burst(0, pre, crc, bla, 1);
    if (skipA) sk6[n] = 1;
    if (two) begin
      req2 = (pos == 0) ? pre + 1 : (pos == 1) ? pre + (bla ? 16 : 8) : pre + (bla ? 16 : 8) + cA;
      add_burst(1, pre, crc, blb, 4);
      if (!(crc && blb)) sk6[n] = 1;
    end
    idx_post = n;
    for (int i = 0; i <= post; i++) push(5, 8'h00, 1'b0, 1'b0);
    idx_done = n;
    push(6, 8'h00, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) push(0, 8'h00, 1'b0, 1'b0);
    s1 = two ? req2 + 1 : idx_post;
    s2 = two ? 0 : idx_done;

    cfg_pre_cyc = AMB_W'(pre); cfg_post_cyc = AMB_W'(post); cfg_crc_en = crc;
    wr_req = 1'b1; wr_bl16 = bla;
    @(posedge clk); @(negedge clk);
    // R10: settings change after acceptance must not matter
    cfg_pre_cyc = ~AMB_W'(pre); cfg_post_cyc = ~AMB_W'(post); cfg_crc_en = ~crc;
    for (int c = 0; c < n; c++) begin
      check(data_take == (ph[c] == 2), "R3", "data_take", {7'b0, data_take}, {7'b0, ph[c] == 2});
      p = (c == 0) ? 0 : ph[c-1];
      case (p)
        0: tag = "R9";
        1: tag = "R2/R10";
        2: tag = "R3";
        3: tag = "R5";
        4: tag = "R8";
        5: tag = "R7/R10";
        default: tag = "R7";
      endcase
      if (c > 0 && sk6[c-1]) tag = "R6";
      check(dq_oe == (p == 2 || p == 3), tag, "dq_oe", {7'b0, dq_oe}, {7'b0, p == 2 || p == 3});
      check(dqs_oe == (p >= 1 && p <= 5), tag, "dqs_oe", {7'b0, dqs_oe}, {7'b0, p >= 1 && p <= 5});
      check(dq == ((c == 0) ? 8'h00 : edq[c-1]), tag, "dq", dq, (c == 0) ? 8'h00 : edq[c-1]);
      check(dm[0] == ((c == 0) ? 1'b0 : edm[c-1]), tag, "dm", {7'b0, dm[0]}, {7'b0, (c == 0) ? 1'b0 : edm[c-1]});
      check(dqs == ((c == 0) ? 1'b0 : eds[c-1]), (p == 2 || p == 3) ? "R4" : tag, "dqs",
            {7'b0, dqs}, {7'b0, (c == 0) ? 1'b0 : eds[c-1]});
      // R8 queued request, R9 stray requests in amble/done/already-queued cycles
      wr_req  = (two && c == req2) || c == s1 || c == s2;
      wr_bl16 = (two && c == req2) ? blb : 1'($urandom);
      wr_data = drv[c]; wr_mask = drvm[c];
      @(negedge clk);
    end
    wr_req = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    wr_req = 1'b1; wr_data = 8'hFF; wr_mask = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({dq, dm, dq_oe, dqs, dqs_oe, data_take} == '0, "R1", "outputs in reset",
          {dq_oe, dqs, dqs_oe, data_take, dm, 3'b0}, 8'h00);
    check(dq == 8'h00, "R1", "dq in reset", dq, 8'h00);
    wr_req = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int pre = 0; pre < 4; pre++)
      for (int post = 0; post < 4; post++)
        for (int crc = 0; crc < 2; crc++)
          for (int bl = 0; bl < 2; bl++)
            run(pre, post, crc[0], bl[0], 1'b0, 1'b0, 0);
    for (int pre = 0; pre < 4; pre++)
      for (int crc = 0; crc < 2; crc++)
        for (int bla = 0; bla < 2; bla++)
          for (int blb = 0; blb < 2; blb++)
            for (int pos = 0; pos < 3; pos++)
              run(pre, (pre + 1) % 4, crc[0], bla[0], 1'b1, blb[0], pos);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule